// File: doc/BRIEF.md
# Dual-Enable Byte-Lane SRAM Core

This block is a clocked register-level model of a 16-bit static memory. Its control pins follow the usual asynchronous SRAM pins. It samples two chip enables of opposite polarity on the system clock: one is active low and one is active high. It also samples an active-low write strobe, an active-low read output enable and two active-low byte-lane selects. The bidirectional data pins are split into a write-data bus, a read-data bus and one drive flag per byte lane. The drive flags stand in for pad output enables.

A word is read one clock after its address and controls are sampled. Writes are byte masked: only the lanes whose select is low change. The depth is set by the address-width parameter. A full-size instance uses 19 address bits, for 524,288 words. The default is kept small so that the array stays light in simulation.

Top module: `dual_enable_sram`

## Requirements
- R1: The core is selected only when `ce_lo_n` is 0 and `ce_hi` is 1. A cycle sampled while it is not selected writes nothing. One clock later that cycle gives `standby` = 1 and `lane_oe` = 0.
- R2: A selected cycle with `wr_n` = 0 writes `wdata` into the word at `addr`. This happens whatever level `rd_en_n` has.
- R3: In any clock period in which the core is selected and `wr_n` is 0, `lane_oe` is 0 at once, without waiting for a clock edge.
- R4: A selected cycle with `wr_n` = 1 and `rd_en_n` = 0 is a read. One clock later, `lane_oe` equals the inverse of the sampled `byte_n`, and `rdata` holds the stored word in the enabled lanes.
- R5: A selected cycle with `wr_n` = 1 and `rd_en_n` = 1 writes nothing. One clock later it gives `lane_oe` = 0.
- R6: Bit 0 of `byte_n` and `lane_oe` belongs to data bits 7:0. Bit 1 belongs to bits 15:8. When `byte_n` = 2'b11, a cycle neither writes nor drives.
- R7: In a write, a lane whose `byte_n` bit is 1 keeps its previous stored byte.
- R8: Each `rdata` byte whose `lane_oe` bit is 0 reads as zero.
- R9: While reset is held, and for the two clocks of synchronous release after it, `lane_oe` = 0, `standby` = 1 and `rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_lo_n | input | 1 | Active-low chip enable |
| ce_hi | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_en_n | input | 1 | Active-low read output enable |
| byte_n | input | 2 | Active-low lane selects, bit 0 = low byte |
| addr | input | ADDR_W | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Registered read data, zero on undriven lanes |
| lane_oe | output | 2 | Per-lane output drive flag |
| standby | output | 1 | Deselected flag, registered |

## Verification
On every clock, the assertions check these rules:
- the drive flags are off while standby is set;
- no lane drives during a write strobe;
- a read produces the lane-drive pattern of the sampled selects;
- an output-enable-high cycle produces no drive;
- undriven lanes read as zero.

Only the bench's scenarios can show what was stored in the array. That covers byte-masked merges into a word, writes blocked by deselection or by both selects being high, writes taken with the output enable high, and read-back across many addresses.

// File: rtl/dsram_pkg.sv
package dsram_pkg;
  localparam int NUM_LANES = 2;
  typedef logic [NUM_LANES-1:0] lane_vec_t;
endpackage

// File: rtl/dsram_decode.sv
module dsram_decode
  import dsram_pkg::*;
(
  input  logic      ce_lo_n,
  input  logic      ce_hi,
  input  logic      wr_n,
  input  logic      rd_en_n,
  input  lane_vec_t byte_n,
  output logic      selected,
  output logic      wr_go,
  output lane_vec_t lane_wr,
  output lane_vec_t lane_rd,
  output logic      rd_go
);
  always_comb begin
    selected = ~ce_lo_n & ce_hi;
    wr_go    = selected & ~wr_n;
    rd_go    = selected & wr_n & ~rd_en_n;
    lane_wr  = {NUM_LANES{wr_go}} & ~byte_n;
    lane_rd  = {NUM_LANES{rd_go}} & ~byte_n;
  end
endmodule

// File: rtl/dsram_lane_bank.sv
module dsram_lane_bank
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int DEPTH  = 1 << ADDR_W,
  localparam int WORD_W = NUM_LANES * LANE_W
) (
  input  logic              clk,
  input  lane_vec_t         lane_wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rd_word
);
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    logic [LANE_W-1:0] cells [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_wr[g]) begin
        cells[addr] <= wdata[g*LANE_W +: LANE_W];
      end
    end

    assign rd_word[g*LANE_W +: LANE_W] = cells[addr];
  end
endmodule

// File: rtl/dsram_rd_stage.sv
module dsram_rd_stage
  import dsram_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              selected,
  input  logic              rd_go,
  input  lane_vec_t         lane_rd,
  input  logic [WORD_W-1:0] rd_word,
  output lane_vec_t         drive_q,
  output logic [WORD_W-1:0] data_q,
  output logic              stby_q
);
  lane_vec_t         drive_d;
  logic [WORD_W-1:0] data_d;
  logic              stby_d;

  always_comb begin
    drive_d = lane_rd;
    stby_d  = ~selected;
    data_d  = data_q;
    if (rd_go) begin
      data_d = rd_word;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      data_q  <= '0;
      stby_q  <= 1'b1;
    end else begin
      drive_q <= drive_d;
      data_q  <= data_d;
      stby_q  <= stby_d;
    end
  end
endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import dsram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LANE_W = 8,
  localparam int WORD_W = NUM_LANES * LANE_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ce_lo_n,
  input  logic                 ce_hi,
  input  logic                 wr_n,
  input  logic                 rd_en_n,
  input  logic [NUM_LANES-1:0] byte_n,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [WORD_W-1:0]    wdata,
  output logic [WORD_W-1:0]    rdata,
  output logic [NUM_LANES-1:0] lane_oe,
  output logic                 standby
);
  logic              rst_meta_n;
  logic              rst_sync_n;
  logic              selected;
  logic              wr_go;
  logic              rd_go;
  lane_vec_t         lane_wr;
  lane_vec_t         lane_rd;
  lane_vec_t         drive_q;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  dsram_decode u_decode (
    .ce_lo_n (ce_lo_n),
    .ce_hi   (ce_hi),
    .wr_n    (wr_n),
    .rd_en_n (rd_en_n),
    .byte_n  (byte_n),
    .selected(selected),
    .wr_go   (wr_go),
    .lane_wr (lane_wr),
    .lane_rd (lane_rd),
    .rd_go   (rd_go)
  );

  dsram_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
    .clk    (clk),
    .lane_wr(lane_wr),
    .addr   (addr),
    .wdata  (wdata),
    .rd_word(rd_word)
  );

  dsram_rd_stage #(.WORD_W(WORD_W)) u_rd (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .selected(selected),
    .rd_go   (rd_go),
    .lane_rd (lane_rd),
    .rd_word (rd_word),
    .drive_q (drive_q),
    .data_q  (data_q),
    .stby_q  (standby)
  );

  // A write strobe withdraws lane drive in the same period.
  assign lane_oe = drive_q & ~{NUM_LANES{wr_go}};

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_mask
    assign rdata[g*LANE_W +: LANE_W] = lane_oe[g] ? data_q[g*LANE_W +: LANE_W] : '0;
  end
endmodule

// File: rtl/dsram_checker.sv
module dsram_checker #(
  parameter int LANE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ce_lo_n,
  input logic              ce_hi,
  input logic              wr_n,
  input logic              rd_en_n,
  input logic [1:0]        byte_n,
  input logic [2*LANE_W-1:0] rdata,
  input logic [1:0]        lane_oe,
  input logic              standby
);
  logic sel_now;
  assign sel_now = !ce_lo_n && ce_hi;

  a_r1_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    standby |-> lane_oe == 2'b00);

  a_r1_deselect_flag: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_now |=> standby);

  a_r3_no_drive_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && !wr_n) |-> lane_oe == 2'b00);

  a_r4_read_drive: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && wr_n && !rd_en_n) |=> ((sel_now && !wr_n) || lane_oe == ~$past(byte_n)));

  a_r5_oe_high_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_now && wr_n && rd_en_n) |=> lane_oe == 2'b00);

  a_r8_undriven_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (lane_oe[0] || rdata[LANE_W-1:0] == '0) && (lane_oe[1] || rdata[2*LANE_W-1:LANE_W] == '0));
endmodule

bind dual_enable_sram dsram_checker #(.LANE_W(LANE_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .ce_lo_n(ce_lo_n),
  .ce_hi  (ce_hi),
  .wr_n   (wr_n),
  .rd_en_n(rd_en_n),
  .byte_n (byte_n),
  .rdata  (rdata),
  .lane_oe(lane_oe),
  .standby(standby)
);

// File: tb/dual_enable_sram_test.sv
module dual_enable_sram_test;
  localparam int AW = 10;

  typedef struct {
    logic [1:0]  oe;
    logic [15:0] data;
    logic        stby;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce_lo_n = 1'b1;
  logic        ce_hi = 1'b0;
  logic        wr_n = 1'b1;
  logic        rd_en_n = 1'b1;
  logic [1:0]  byte_n = 2'b11;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic [1:0]  lane_oe;
  logic        standby;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 0;
  exp_t q[$];
  logic [15:0] shadow [1<<AW];

  always #4 clk = ~clk;

  dual_enable_sram #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .ce_lo_n(ce_lo_n), .ce_hi(ce_hi), .wr_n(wr_n),
    .rd_en_n(rd_en_n), .byte_n(byte_n), .addr(addr), .wdata(wdata),
    .rdata(rdata), .lane_oe(lane_oe), .standby(standby)
  );

  task automatic check(input string tag, input logic [1:0] oe, input logic [15:0] d, input logic s);
    n_cmp++;
    if (lane_oe !== oe || rdata !== d || standby !== s) begin
      n_bad++;
      $display("FAIL %s: got oe=%b data=%h stby=%b, expected oe=%b data=%h stby=%b",
               tag, lane_oe, rdata, standby, oe, d, s);
    end
  endtask

  // Driver: applies one cycle of controls at the falling edge, predicts the result.
  task automatic op(input string tag, input logic cl, input logic ch, input logic w,
                    input logic r, input logic [1:0] b, input int a, input logic [15:0] d);
    exp_t e;
    logic sel;
    @(negedge clk);
    ce_lo_n = cl; ce_hi = ch; wr_n = w; rd_en_n = r; byte_n = b;
    addr = AW'(a); wdata = d;
    sel = !cl && ch;
    if (sel && !w) begin
      if (!b[0]) shadow[a][7:0]  = d[7:0];
      if (!b[1]) shadow[a][15:8] = d[15:8];
    end
    e.oe   = (sel && w && !r) ? ~b : 2'b00;
    e.data = {e.oe[1] ? shadow[a][15:8] : 8'h00, e.oe[0] ? shadow[a][7:0] : 8'h00};
    e.stby = !sel;
    e.tag  = tag;
    q.push_back(e);
  endtask

  // Monitor: compares each result shortly after the edge that produces it.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, e.oe, e.data, e.stby);
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R9 reset held", 2'b00, 16'h0000, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 release", 2'b00, 16'h0000, 1'b1);
    repeat (2) @(negedge clk);

    op("R2 write oe high", 0, 1, 0, 1, 2'b00, 5, 16'hA1B2);
    op("R4 read full",     0, 1, 1, 0, 2'b00, 5, 16'h0000);
    op("R2 write oe low",  0, 1, 0, 0, 2'b00, 9, 16'h3C3C);
    op("R4 read 9",        0, 1, 1, 0, 2'b00, 9, 16'h0000);
    op("R7 low lane wr",   0, 1, 0, 1, 2'b10, 5, 16'hFFCC);
    op("R7 read merge",    0, 1, 1, 0, 2'b00, 5, 16'h0000);
    op("R7 high lane wr",  0, 1, 0, 1, 2'b01, 5, 16'h77EE);
    op("R6 R8 read low",   0, 1, 1, 0, 2'b10, 5, 16'h0000);
    op("R6 R8 read high",  0, 1, 1, 0, 2'b01, 5, 16'h0000);
    op("R6 no-lane write", 0, 1, 0, 1, 2'b11, 5, 16'h0000);
    op("R6 no-lane read",  0, 1, 1, 0, 2'b11, 5, 16'h0000);
    op("R6 read after",    0, 1, 1, 0, 2'b00, 5, 16'h0000);
    op("R1 write ce_lo_n high", 1, 1, 0, 1, 2'b00, 5, 16'h1111);
    op("R1 write ce_hi low",    0, 0, 0, 1, 2'b00, 5, 16'h2222);
    op("R1 read deselected",    1, 0, 1, 0, 2'b00, 5, 16'h0000);
    op("R1 read kept",          0, 1, 1, 0, 2'b00, 5, 16'h0000);
    op("R5 oe high",            0, 1, 1, 1, 2'b00, 5, 16'h0000);

    // R3: drive from a read vanishes as soon as a write strobe is applied.
    op("R3 read before write",  0, 1, 1, 0, 2'b00, 9, 16'h0000);
    @(posedge clk); #3;
    op("R3 write", 0, 1, 0, 0, 2'b00, 6, 16'h1234);
    #1;
    n_cmp++;
    if (lane_oe !== 2'b00) begin
      n_bad++;
      $display("FAIL R3 same-period: got oe=%b, expected oe=00", lane_oe);
    end
    op("R3 read 6", 0, 1, 1, 0, 2'b00, 6, 16'h0000);

    for (int i = 0; i < 16; i++) begin
      op("R2 pattern write", 0, 1, 0, i[0], 2'b00, 100 + i * 7, 16'(i * 16'h0101) ^ 16'h5A3C);
    end
    for (int i = 0; i < 16; i++) begin
      op("R4 pattern read", 0, 1, 1, 0, 2'b00, 100 + i * 7, 16'h0000);
    end

    op("R1 idle", 1, 0, 1, 1, 2'b11, 0, 16'h0000);
    repeat (3) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule